// File: doc/BRIEF.md
# Bit-banged serial EEPROM responder

This block stands in for a small serial EEPROM that sits behind one memory-mapped control word. Software never sees a real serial clock: it toggles a clock bit, a chip-select bit and a serial-input bit by writing the control word. It reads the serial-output bit back from the same word. Each write that moves the clock bit from low to high counts as one serial clock edge. The block sequences those edges into an 8-bit command, an optional 8-bit byte address and a stream of output bits.

Two commands are understood. The word-read command takes a byte address and halves it to pick one 16-bit word from a 64-word read-only store. It then presents that word most significant bit first. The status command returns eight zero bits. Any other command, or a byte address whose word index falls outside the store, raises a sticky error output that only reset clears. A request bit in the same word is answered at once by a grant bit.

Top module: `sprom_resp`

## Requirements
- R1: After reset, a read of the control word returns 0, `err_o` is 0 and the command sequencer waits for the first command bit.
- R2: The control word sits at host address `CTRL_ADDR` (default 0x20). Its bits are: bit 0 serial clock, bit 1 chip select, bit 2 serial input, bit 3 serial output (read only), bit 4 access request, bit 5 access grant (read only). All other bits read 0. A read returns data on `rdata_o` one cycle after `rd_en_i`. Writes to any other address change nothing, and reads of any other address return 0.
- R3: The sequencer advances only on a write to the control word that changes the stored clock bit from 0 to 1. It samples the serial-input bit carried by that same write. No other write advances the sequencer or changes the serial output.
- R4: The first 8 clock edges of a command shift the serial input into the opcode, most significant bit first. 0x03 selects word read and 0x05 selects status read.
- R5: After opcode 0x03, the next 8 edges shift in a byte address, most significant bit first. The word index is the byte address shifted right by one. The following 16 edges set the serial output to bits 15 down to 0 of that word, one bit per edge.
- R6: After opcode 0x05, no address is taken, and each of the next 8 edges sets the serial output to 0.
- R7: The 16th data edge of a word read, or the 8th bit of a status read, ends the command. The next edge is then taken as the first opcode bit of a new command.
- R8: Word 0 of the store holds 0xBABA and every other word holds 0.
- R9: Every write to the control word sets the grant bit equal to the request bit of that write.
- R10: If a completed 8-bit opcode is neither 0x03 nor 0x05, `err_o` rises on that edge. Later edges leave the serial output unchanged. `err_o` stays high until reset.
- R11: If a byte address gives a word index of 64 or more, `err_o` rises on the last address edge and the 16 data bits read as 0. An index of 63 raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | HOST_AW (8) | Host word address |
| wdata_i | input | HOST_W (32) | Host write data |
| rdata_o | output | HOST_W (32) | Host read data, valid the cycle after `rd_en_i` |
| err_o | output | 1 | Sticky protocol/range error |

## Verification
A write and every effect it causes land on the clock edge that samples the strobe. These effects are the stored control bits, the grant, the sequencer step, the new serial-output value and `err_o`. Read data is registered and appears one cycle after the read strobe. The bench drives each strobe on a falling edge for one cycle and releases it on the next falling edge. It samples `err_o` at that next falling edge. It fetches the serial output with a separate read whose data it samples one full cycle later, so every sample lies half a cycle away from the edge that produced it.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  // control word bit positions
  localparam int unsigned CB_SCLK = 0;
  localparam int unsigned CB_CSEL = 1;
  localparam int unsigned CB_SDI  = 2;
  localparam int unsigned CB_SDO  = 3;
  localparam int unsigned CB_REQ  = 4;
  localparam int unsigned CB_GNT  = 5;

  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_STAT = 8'h05;

  typedef enum logic [2:0] {
    PH_OP   = 3'd0,
    PH_ADDR = 3'd1,
    PH_DATA = 3'd2,
    PH_STAT = 3'd3,
    PH_BAD  = 3'd4
  } phase_e;
endpackage

// File: rtl/sprom_host.sv
module sprom_host
  import sprom_pkg::*;
#(
  parameter int unsigned HOST_W = 32,
  parameter int unsigned HOST_AW = 8,
  parameter logic [HOST_AW-1:0] CTRL_ADDR = 8'h20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [HOST_W-1:0]  wdata_i,
  input  logic               sdo_i,
  output logic               step_o,
  output logic               sdi_o,
  output logic               gnt_o,
  output logic [HOST_W-1:0]  rdata_o
);
  logic wr_hit, rd_hit;
  logic sclk_q, csel_q, sdi_q, req_q, gnt_q;
  logic [HOST_W-1:0] view, rdata_q;
  logic unused_bits;

  assign wr_hit = wr_en_i && (addr_i == CTRL_ADDR);
  assign rd_hit = rd_en_i && (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csel_q <= 1'b0;
      sdi_q  <= 1'b0;
      req_q  <= 1'b0;
      gnt_q  <= 1'b0;
    end else if (wr_hit) begin
      sclk_q <= wdata_i[CB_SCLK];
      csel_q <= wdata_i[CB_CSEL];
      sdi_q  <= wdata_i[CB_SDI];
      req_q  <= wdata_i[CB_REQ];
      gnt_q  <= wdata_i[CB_REQ];
    end
  end

  always_comb begin
    view          = '0;
    view[CB_SCLK] = sclk_q;
    view[CB_CSEL] = csel_q;
    view[CB_SDI]  = sdi_q;
    view[CB_SDO]  = sdo_i;
    view[CB_REQ]  = req_q;
    view[CB_GNT]  = gnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_hit ? view : '0;
  end

  // rising serial clock: decided against the stored bit, sampled with this write
  assign step_o  = wr_hit && wdata_i[CB_SCLK] && !sclk_q;
  assign sdi_o   = wdata_i[CB_SDI];
  assign gnt_o   = gnt_q;
  assign rdata_o = rdata_q;

  assign unused_bits = ^{wdata_i[HOST_W-1:CB_GNT], wdata_i[CB_SDO]};
endmodule

// File: rtl/sprom_store.sv
module sprom_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS = 64,
  parameter int unsigned IDX_W = 7,
  parameter logic [DATA_W-1:0] PRESET = 16'hBABA
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned SEL_W = $clog2(WORDS);

  logic [DATA_W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (g == 0) begin : g_pre
      assign mem[g] = PRESET;
    end else begin : g_zero
      assign mem[g] = '0;
    end
  end

  always_comb begin
    if (idx_i < IDX_W'(WORDS)) word_o = mem[idx_i[SEL_W-1:0]];
    else                       word_o = '0;
  end
endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
  import sprom_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS = 64,
  parameter int unsigned OP_W = 8,
  parameter int unsigned ADR_W = 8,
  parameter int unsigned STS_BITS = 8,
  parameter logic [OP_W-1:0] OPC_RD = OPC_READ,
  parameter logic [OP_W-1:0] OPC_ST = OPC_STAT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic                sdi_i,
  input  logic [DATA_W-1:0]   word_i,
  output logic [ADR_W-2:0]    idx_o,
  output logic                sdo_o,
  output phase_e              phase_o,
  output logic                err_o
);
  localparam int unsigned IDX_W = ADR_W - 1;
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  phase_e phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OP_W-2:0]  op_q, op_d;
  logic [ADR_W-1:0] adr_q, adr_d;
  logic oor_q, oor_d, sdo_q, sdo_d, err_q, err_d;

  logic [OP_W-1:0]  op_full;
  logic [ADR_W-1:0] adr_full;
  logic [BIT_W-1:0] bsel;
  logic last_op, last_adr, last_dat, last_sts;

  assign op_full  = {op_q, sdi_i};
  assign adr_full = {adr_q[ADR_W-2:0], sdi_i};
  assign bsel     = BIT_W'(DATA_W - 1) - cnt_q[BIT_W-1:0];
  assign last_op  = (cnt_q == CNT_W'(OP_W - 1));
  assign last_adr = (cnt_q == CNT_W'(ADR_W - 1));
  assign last_dat = (cnt_q == CNT_W'(DATA_W - 1));
  assign last_sts = (cnt_q == CNT_W'(STS_BITS - 1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    adr_d   = adr_q;
    oor_d   = oor_q;
    sdo_d   = sdo_q;
    err_d   = err_q;
    if (step_i) begin
      unique case (phase_q)
        PH_OP: begin
          op_d = op_full[OP_W-2:0];
          if (last_op) begin
            cnt_d = '0;
            op_d  = '0;
            if (op_full == OPC_RD)      phase_d = PH_ADDR;
            else if (op_full == OPC_ST) phase_d = PH_STAT;
            else begin
              phase_d = PH_BAD;
              err_d   = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          adr_d = adr_full;
          if (last_adr) begin
            cnt_d   = '0;
            phase_d = PH_DATA;
            if (adr_full[ADR_W-1:1] >= IDX_W'(WORDS)) begin
              oor_d = 1'b1;
              err_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          sdo_d = oor_q ? 1'b0 : word_i[bsel];
          if (last_dat) begin
            phase_d = PH_OP;
            cnt_d   = '0;
            adr_d   = '0;
            oor_d   = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_STAT: begin
          sdo_d = 1'b0;
          if (last_sts) begin
            phase_d = PH_OP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_BAD: err_d = 1'b1;
        default: begin
          phase_d = PH_BAD;
          err_d   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OP;
      cnt_q   <= '0;
      op_q    <= '0;
      adr_q   <= '0;
      oor_q   <= 1'b0;
      sdo_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      adr_q   <= adr_d;
      oor_q   <= oor_d;
      sdo_q   <= sdo_d;
      err_q   <= err_d;
    end
  end

  assign idx_o   = adr_q[ADR_W-1:1];
  assign sdo_o   = sdo_q;
  assign phase_o = phase_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sprom_resp.sv
module sprom_resp
  import sprom_pkg::*;
#(
  parameter int unsigned HOST_W = 32,
  parameter int unsigned HOST_AW = 8,
  parameter logic [HOST_AW-1:0] CTRL_ADDR = 8'h20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS = 64,
  parameter int unsigned OP_W = 8,
  parameter int unsigned ADR_W = 8,
  parameter int unsigned STS_BITS = 8,
  parameter logic [DATA_W-1:0] PRESET = 16'hBABA
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [HOST_W-1:0]  wdata_i,
  output logic [HOST_W-1:0]  rdata_o,
  output logic               err_o
);
  localparam int unsigned IDX_W = ADR_W - 1;

  logic step_w, sdi_w, sdo_w, gnt_w;
  logic [IDX_W-1:0]  idx_w;
  logic [DATA_W-1:0] word_w;
  phase_e phase_w;

  sprom_host #(
    .HOST_W(HOST_W), .HOST_AW(HOST_AW), .CTRL_ADDR(CTRL_ADDR)
  ) u_host (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .sdo_i(sdo_w), .step_o(step_w),
    .sdi_o(sdi_w), .gnt_o(gnt_w), .rdata_o(rdata_o)
  );

  sprom_seq #(
    .DATA_W(DATA_W), .WORDS(WORDS), .OP_W(OP_W), .ADR_W(ADR_W),
    .STS_BITS(STS_BITS), .OPC_RD(OP_W'(OPC_READ)), .OPC_ST(OP_W'(OPC_STAT))
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_w), .sdi_i(sdi_w),
    .word_i(word_w), .idx_o(idx_w), .sdo_o(sdo_w), .phase_o(phase_w),
    .err_o(err_o)
  );

  sprom_store #(
    .DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W), .PRESET(PRESET)
  ) u_store (
    .idx_i(idx_w), .word_o(word_w)
  );
endmodule

// File: rtl/sprom_resp_chk.sv
module sprom_resp_chk
  import sprom_pkg::*;
#(
  parameter int unsigned HOST_W = 32,
  parameter int unsigned HOST_AW = 8,
  parameter logic [HOST_AW-1:0] CTRL_ADDR = 8'h20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [HOST_AW-1:0] addr_i,
  input logic [HOST_W-1:0]  wdata_i,
  input logic [HOST_W-1:0]  rdata_o,
  input logic               err_o,
  input logic               step_i,
  input logic               sdo_i,
  input logic               gnt_i,
  input phase_e             phase_i
);
  a_r3_sdo_only_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(sdo_i));

  a_r9_grant_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CTRL_ADDR) |=> gnt_i == $past(wdata_i[CB_REQ]));

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r10_err_needs_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(step_i));

  a_r6_status_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_i == PH_STAT) |=> !sdo_i);

  a_r2_other_addr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != CTRL_ADDR) |=> rdata_o == '0);
endmodule

bind sprom_resp sprom_resp_chk #(
  .HOST_W(HOST_W), .HOST_AW(HOST_AW), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
  .step_i(step_w), .sdo_i(sdo_w), .gnt_i(gnt_w), .phase_i(phase_w)
);

// File: tb/sprom_resp_tb.sv
module sprom_resp_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTRL = 8'h20;
  localparam logic [7:0] OTHER = 8'h24;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sprom_resp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err)
  );

  function automatic logic [15:0] model_word(input int idx);
    return (idx == 0) ? 16'hBABA : 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // one serial clock: low phase then rising write, then fetch serial output
  task automatic clk_bit(input logic b, output logic s);
    logic [31:0] r;
    host_wr(CTRL, 32'h2 | (32'(b) << 2));
    host_wr(CTRL, 32'h3 | (32'(b) << 2));
    host_rd(CTRL, r);
    s = r[3];
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
  endtask

  task automatic read_word(input string tag, input logic [7:0] badr, input logic [15:0] exp);
    logic s;
    send_byte(8'h03);
    send_byte(badr);
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, s);
      check(tag, 32'(s), 32'(exp[i]));
    end
  endtask

  task automatic t_reset();
    logic [31:0] r;
    do_reset();
    host_rd(CTRL, r);
    check("R1 reset ctrl", r, 32'h0);
    check("R1 reset err", 32'(err), 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] r;
    host_wr(CTRL, 32'hFFFF_FFF6);
    host_rd(CTRL, r);
    check("R2 R9 layout and grant", r, 32'h0000_0036);
    host_wr(CTRL, 32'h0000_0000);
    host_rd(CTRL, r);
    check("R9 grant drops with request", r, 32'h0);
    host_wr(OTHER, 32'h0000_001F);
    host_rd(CTRL, r);
    check("R2 other address write ignored", r, 32'h0);
    host_rd(OTHER, r);
    check("R2 other address reads zero", r, 32'h0);
  endtask

  task automatic t_read_basic();
    read_word("R5 R8 word0 via byte 0x00", 8'h00, model_word(0));
    read_word("R5 R7 word0 via byte 0x01", 8'h01, model_word(0));
    read_word("R8 word1 via byte 0x02", 8'h02, model_word(1));
    read_word("R11 index 63 no error data", 8'h7E, model_word(63));
    check("R11 index 63 no error", 32'(err), 32'h0);
  endtask

  task automatic t_no_advance();
    logic [31:0] r;
    logic s, s2;
    logic [7:0] opc = 8'h03;
    for (int i = 7; i >= 0; i--) begin
      host_wr(CTRL, 32'h2 | (32'(opc[i]) << 2));
      host_wr(OTHER, 32'h7);
      host_wr(CTRL, 32'h3 | (32'(opc[i]) << 2));
      host_wr(CTRL, 32'h3 | (32'(~opc[i]) << 2));
      host_wr(CTRL, 32'h3);
    end
    send_byte(8'h00);
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, s);
      check("R3 R4 read with idle writes", 32'(s), 32'(model_word(0) >> i) & 32'h1);
      host_wr(CTRL, 32'h7);
      host_rd(CTRL, r);
      s2 = r[3];
      check("R3 held clock keeps sdo", 32'(s2), 32'(s));
    end
  endtask

  task automatic t_status();
    logic s;
    send_byte(8'h05);
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      check("R6 status bit zero", 32'(s), 32'h0);
    end
    read_word("R7 read right after status", 8'h00, model_word(0));
    check("R6 no error", 32'(err), 32'h0);
  endtask

  task automatic t_range();
    logic s;
    do_reset();
    send_byte(8'h03);
    for (int i = 7; i >= 1; i--) clk_bit(i == 7, s);
    check("R11 error not before last address bit", 32'(err), 32'h0);
    clk_bit(1'b0, s);
    check("R11 index 64 raises error", 32'(err), 32'h1);
    for (int i = 0; i < 16; i++) begin
      clk_bit(1'b1, s);
      check("R11 out of range data zero", 32'(s), 32'h0);
    end
    read_word("R7 R11 read after range error", 8'h00, model_word(0));
    check("R10 error sticky", 32'(err), 32'h1);
  endtask

  task automatic t_bad();
    logic s;
    logic [7:0] opc = 8'h06;
    do_reset();
    check("R1 reset clears error", 32'(err), 32'h0);
    for (int i = 7; i >= 1; i--) clk_bit(opc[i], s);
    check("R10 no error before 8th bit", 32'(err), 32'h0);
    clk_bit(opc[0], s);
    check("R10 unknown opcode error", 32'(err), 32'h1);
    for (int i = 0; i < 4; i++) begin
      clk_bit(1'b1, s);
      check("R10 sdo unchanged after bad opcode", 32'(s), 32'h0);
      check("R10 error stays", 32'(err), 32'h1);
    end
    do_reset();
    check("R1 error cleared by reset", 32'(err), 32'h0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_layout();
    t_read_basic();
    t_no_advance();
    t_status();
    t_range();
    t_bad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule